// File: doc/BRIEF.md
# Multiply-Accumulate Datapath for Multi-Precision Crypto Arithmetic

This block is the arithmetic core of a small cryptographic processor. Each cycle it can take two 16-bit operands from the two memory read ports. It feeds them through a single-cycle 16x16 multiplier or a first 40-bit adder. A second 40-bit adder then merges that result with a 40-bit accumulator. A bitwise logic unit sits beside this path for hash rounds. Either operand may be replaced by one of the constants 0, 1 or 0xFFFF. This lets a sequencer form increments, masks and complements without first placing them in memory.

A per-cycle control word sets up the operation. It picks the operand sources and the operation, and it sets three accumulator controls: clear the base, shift the base right by one word, and load the result. It also carries a writeback request. On a writeback, the accumulator's low word goes to port A and its next word goes to port B, both in the following cycle. Writeback and shift can be asked for together. The column that is finished is then stored while its carries move down into the next column of a multi-word product. The 8 guard bits above 32 absorb the carries of many summed products. An external sequencer drives the control word. The memories are outside this block.

Top module: `mac_datapath`

## Requirements
- R1: A synchronous active-high reset sets the accumulator to 0 and deasserts both write enables on the following edge.
- R2: Each operand source select picks the port value for code 0, 0x0000 for code 1, 0x0001 for code 2 and 0xFFFF for code 3.
- R3: Operation 0 (MAC) loads base + A*B. The product is the full unsigned 32-bit product, zero-extended to 40 bits.
- R4: Operation 1 (ADD) loads base + A + B. Operation 2 (SUB) loads base + A − B. Both are formed in 40-bit two's complement and wrap modulo 2^40.
- R5: Operations 3 (AND), 4 (OR), 5 (XOR) and 6 or 7 (pass A) load the 16-bit bitwise result zero-extended to 40 bits. For these operations the base is discarded.
- R6: The base is 0 when clear is set. Otherwise it is the accumulator shifted right logically by 16 when shift is set. Otherwise it is the accumulator itself. Clear takes priority over shift.
- R7: When load is low, a valid control word leaves the base in the accumulator. Clear alone therefore zeroes it, and shift alone moves it down one word.
- R8: A valid word with writeback set raises both write enables for exactly the next cycle. In that cycle port A carries bits 15:0 and port B carries bits 31:16 of the accumulator as it stood before that word's update.
- R9: While valid is low the accumulator holds its value and both write enables are low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Control word is valid this cycle |
| op_i | input | 3 | Operation select (see R3 to R5) |
| sel_a_i | input | 2 | Source select for operand A |
| sel_b_i | input | 2 | Source select for operand B |
| clr_i | input | 1 | Use zero as accumulator base |
| shr_i | input | 1 | Use accumulator shifted right by 16 as base |
| load_i | input | 1 | Load the operation result into the accumulator |
| wb_i | input | 1 | Write back low and high accumulator words |
| a_i | input | 16 | Operand from memory port A |
| b_i | input | 16 | Operand from memory port B |
| acc_o | output | 40 | Accumulator value |
| a_o | output | 16 | Write data to port A (accumulator bits 15:0) |
| b_o | output | 16 | Write data to port B (accumulator bits 31:16) |
| wa_o | output | 1 | Write enable for port A |
| wb_o | output | 1 | Write enable for port B |

## Verification
The bench aims at the largest product, 0xFFFF squared, added onto a nearly full accumulator. A multiplier cut to 16 bits, or an adder without guard bits, would lose the upper columns there. It drives a subtraction from zero, which must wrap to all ones across the full 40 bits and not only the low 16 bits. It issues writeback and shift in the same word to show that the stored words are the pre-shift accumulator. A design that sampled after the update would write the shifted column. It also checks that clear overrides shift, and that idle cycles leave everything untouched.

// File: rtl/mac_datapath.sv
module mac_datapath #(
  parameter int W  = 16,
  parameter int AW = 40
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          valid_i,
  input  logic [2:0]    op_i,
  input  logic [1:0]    sel_a_i,
  input  logic [1:0]    sel_b_i,
  input  logic          clr_i,
  input  logic          shr_i,
  input  logic          load_i,
  input  logic          wb_i,
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  output logic [AW-1:0] acc_o,
  output logic [W-1:0]  a_o,
  output logic [W-1:0]  b_o,
  output logic          wa_o,
  output logic          wb_o
);
  localparam int PW = 2 * W;

  logic [W-1:0]  opa, opb, lres;
  logic [PW-1:0] prod;
  logic [AW-1:0] ea, eb, add1, base, add2, nxt;
  logic          is_logic;

  function automatic logic [W-1:0] pick(input logic [1:0] s, input logic [W-1:0] v);
    case (s)
      2'd0:    pick = v;
      2'd1:    pick = '0;
      2'd2:    pick = W'(1);
      default: pick = '1;
    endcase
  endfunction

  assign opa  = pick(sel_a_i, a_i);
  assign opb  = pick(sel_b_i, b_i);
  assign prod = opa * opb;
  assign ea   = AW'(opa);
  assign eb   = AW'(opb);

  always_comb begin
    case (op_i)
      3'd0:    add1 = AW'(prod);
      3'd1:    add1 = ea + eb;
      3'd2:    add1 = ea + ~eb + AW'(1);
      default: add1 = '0;
    endcase
  end

  always_comb begin
    case (op_i)
      3'd3:    lres = opa & opb;
      3'd4:    lres = opa | opb;
      3'd5:    lres = opa ^ opb;
      default: lres = opa;
    endcase
  end

  assign is_logic = op_i > 3'd2;
  assign base = clr_i ? '0 : (shr_i ? (acc_o >> W) : acc_o);
  assign add2 = base + add1;
  assign nxt  = is_logic ? AW'(lres) : add2;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_o <= '0;
      a_o   <= '0;
      b_o   <= '0;
      wa_o  <= 1'b0;
      wb_o  <= 1'b0;
    end else begin
      wa_o <= valid_i & wb_i;
      wb_o <= valid_i & wb_i;
      if (valid_i) begin
        acc_o <= load_i ? nxt : base;
        if (wb_i) begin
          a_o <= acc_o[W-1:0];
          b_o <= acc_o[PW-1:W];
        end
      end
    end
  end
endmodule

module mac_datapath_chk #(
  parameter int W  = 16,
  parameter int AW = 40
) (
  input logic          clk,
  input logic          rst,
  input logic          valid_i,
  input logic [2:0]    op_i,
  input logic [1:0]    sel_a_i,
  input logic [1:0]    sel_b_i,
  input logic          clr_i,
  input logic          shr_i,
  input logic          load_i,
  input logic          wb_i,
  input logic [W-1:0]  a_i,
  input logic [W-1:0]  b_i,
  input logic [AW-1:0] acc_o,
  input logic [W-1:0]  a_o,
  input logic [W-1:0]  b_o,
  input logic          wa_o,
  input logic          wb_o
);
  // R1
  reset_clears_chk: assert property (@(posedge clk) rst |=> (acc_o == '0 && !wa_o && !wb_o));
  // R9
  idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> ($stable(acc_o) && !wa_o && !wb_o));
  // R8
  writeback_words_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_i && wb_i) |=> (wa_o && wb_o && a_o == $past(acc_o[W-1:0]) && b_o == $past(acc_o[2*W-1:W])));
  // R7
  clear_only_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_i && !load_i && clr_i) |=> acc_o == '0);
  // R6
  shift_only_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_i && !load_i && !clr_i && shr_i) |=> acc_o == ($past(acc_o) >> W));
  // R3
  mac_product_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_i && load_i && clr_i && op_i == 3'd0 && sel_a_i == 2'd0 && sel_b_i == 2'd0)
      |=> acc_o == AW'($past(a_i) * $past(b_i)));
  // R5
  logic_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_i && load_i && op_i > 3'd2) |=> acc_o[AW-1:W] == '0);
endmodule

bind mac_datapath mac_datapath_chk #(.W(W), .AW(AW)) u_chk (.*);

// File: tb/mac_datapath_test.sv
module mac_datapath_test;
  localparam int CLK_PERIOD = 10;
  localparam longint unsigned M40 = 64'hFF_FFFF_FFFF;

  logic clk = 0, rst = 1, valid_i = 0, clr_i = 0, shr_i = 0, load_i = 0, wb_i = 0;
  logic [2:0] op_i = 0;
  logic [1:0] sel_a_i = 0, sel_b_i = 0;
  logic [15:0] a_i = 0, b_i = 0;
  logic [39:0] acc_o;
  logic [15:0] a_o, b_o;
  logic wa_o, wb_o;

  int checks = 0, fails = 0;
  longint unsigned macc = 0, exp_a = 0, exp_b = 0;
  logic exp_we = 0;
  string cur_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_datapath uut (.*);

  task automatic chk(input string tag, input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic compare();
    chk({cur_tag, " acc"}, longint'(acc_o), macc);
    chk({cur_tag, " wa"}, longint'(wa_o), longint'(exp_we));
    chk({cur_tag, " wb"}, longint'(wb_o), longint'(exp_we));
    if (exp_we) begin
      chk({cur_tag, " port A word"}, longint'(a_o), exp_a);
      chk({cur_tag, " port B word"}, longint'(b_o), exp_b);
    end
  endtask

  function automatic longint unsigned srcval(input logic [1:0] s, input logic [15:0] v);
    case (s)
      2'd0: return longint'(v);
      2'd1: return 0;
      2'd2: return 1;
      default: return 64'hFFFF;
    endcase
  endfunction

  task automatic step(input string tag, input logic v, input logic [2:0] op, input logic [1:0] sa,
                      input logic [1:0] sb, input logic c, input logic sh, input logic ld,
                      input logic w, input logic [15:0] a, input logic [15:0] b);
    longint unsigned oa, ob, base, x, nxt;
    @(negedge clk);
    compare();
    valid_i = v; op_i = op; sel_a_i = sa; sel_b_i = sb; clr_i = c; shr_i = sh;
    load_i = ld; wb_i = w; a_i = a; b_i = b;
    cur_tag = tag;
    oa = srcval(sa, a); ob = srcval(sb, b);
    base = c ? 0 : (sh ? (macc >> 16) : macc);
    case (op)
      3'd0: x = (base + oa * ob) & M40;
      3'd1: x = (base + oa + ob) & M40;
      3'd2: x = (base + oa - ob) & M40;
      3'd3: x = oa & ob;
      3'd4: x = oa | ob;
      3'd5: x = oa ^ ob;
      default: x = oa;
    endcase
    nxt = x;
    if (v) begin
      exp_we = w;
      if (w) begin
        exp_a = macc & 64'hFFFF;
        exp_b = (macc >> 16) & 64'hFFFF;
      end
      macc = ld ? nxt : base;
    end else
      exp_we = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1 reset state checked on the first compare
    // R3 largest product onto cleared base
    step("R3", 1, 0, 0, 0, 1, 0, 1, 0, 16'hFFFF, 16'hFFFF);
    step("R3", 1, 0, 0, 0, 0, 0, 1, 0, 16'hFFFF, 16'hFFFF);
    step("R3", 1, 0, 0, 0, 0, 0, 1, 0, 16'hFFFF, 16'hFFFF);
    // R8 writeback together with shift (R6)
    step("R8", 1, 0, 1, 1, 0, 1, 0, 1, 0, 0);
    step("R6", 1, 0, 0, 0, 0, 1, 1, 1, 16'h1234, 16'h5678);
    // R6 clear wins over shift
    step("R6", 1, 1, 0, 0, 1, 1, 1, 0, 16'h0003, 16'h0004);
    // R4 subtract from zero wraps
    step("R4", 1, 2, 1, 2, 1, 0, 1, 0, 0, 0);
    step("R4", 1, 1, 3, 3, 0, 0, 1, 1, 0, 0);
    step("R4", 1, 2, 0, 0, 0, 0, 1, 1, 16'h0010, 16'h8000);
    // R2 constant sources
    step("R2", 1, 1, 2, 3, 1, 0, 1, 0, 16'hAAAA, 16'h5555);
    step("R2", 1, 6, 3, 0, 0, 0, 1, 0, 16'h0000, 16'h0000);
    step("R2", 1, 6, 1, 0, 0, 0, 1, 0, 16'hBEEF, 16'h0000);
    // R5 logic ops discard base
    step("R5", 1, 0, 3, 3, 0, 0, 1, 0, 0, 0);
    step("R5", 1, 3, 0, 0, 0, 0, 1, 0, 16'hF0F0, 16'hFF00);
    step("R5", 1, 4, 0, 0, 0, 0, 1, 0, 16'hF0F0, 16'h0F0F);
    step("R5", 1, 5, 0, 0, 0, 0, 1, 1, 16'hAAAA, 16'hFFFF);
    step("R5", 1, 7, 0, 0, 0, 0, 1, 0, 16'h1357, 16'h2468);
    // R7 no load: clear alone, shift alone
    step("R7", 1, 0, 0, 0, 0, 0, 1, 0, 16'hFFFF, 16'h0101);
    step("R7", 1, 0, 0, 0, 0, 1, 0, 0, 16'hFFFF, 16'hFFFF);
    step("R7", 1, 0, 0, 0, 1, 0, 0, 0, 16'hFFFF, 16'hFFFF);
    // R9 idle with junk on controls
    step("R9", 1, 0, 0, 0, 0, 0, 1, 0, 16'h4321, 16'h8765);
    step("R9", 0, 2, 3, 3, 1, 1, 1, 1, 16'hFFFF, 16'hFFFF);
    step("R9", 0, 0, 0, 0, 1, 0, 1, 1, 16'h1111, 16'h2222);
    for (int i = 0; i < 400; i++) begin
      logic [2:0] op;
      op = 3'($urandom_range(0, 7));
      step(op < 3 ? (op == 0 ? "R3" : "R4") : "R5",
           ($urandom_range(0, 7) != 0), op, 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
           ($urandom_range(0, 5) == 0), ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) != 0),
           ($urandom_range(0, 2) == 0), 16'($urandom), 16'($urandom));
    end
    step("R9", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    compare();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule